// File: doc/BRIEF.md
# Serially Configured Lookup-Table Logic Cell

This block is a small programmable logic cell. A table of 2^N configuration bits holds the truth table of any function of N logic inputs. The inputs steer a multiplexer tree that picks one table entry. A further configuration bit decides whether the cell output is that entry directly, or the same entry captured by an output flip-flop on the user clock. In the second case the cell acts as one state bit of a larger machine.

All configuration bits, the output-mode bit included, sit in one serial shift chain. The chain moves one place on each clock edge while the shift enable is high, and it holds otherwise. The far end of the chain drives a serial output. Several cells can therefore be strung together and loaded from one bit stream: the bits for the farthest cell go in first. While shifting is enabled, the output flip-flop is held cleared, so that a half-loaded table never reaches the state bit.

Top module: `lut_cell`

## Requirements
- R1: When the mode bit is 0 (direct), `cell_out` equals table entry number `lut_in` (unsigned value of `lut_in`, bit 0 least significant) in the same cycle, with no clock edge in between.
- R2: After exactly N_IN-bit-table-size-plus-one shifts (17 for N_IN=4), the first bit shifted in is the mode bit and the last one is table entry 0. The bits in between fill the entries from the highest index down to 1, in the order they arrive.
- R3: `cfg_dout` always shows the chain end (the mode-bit position). A bit presented on `cfg_din` therefore appears on `cfg_dout` after 17 shifts, which lets the serial output of one cell feed `cfg_din` of the next.
- R4: While `cfg_shift_en` is 0, the table and mode bit keep their values whatever `cfg_din` does.
- R5: When the mode bit is 1 (registered), `cell_out` after a rising edge with `cfg_shift_en` at 0 equals the table entry selected by `lut_in` just before that edge.
- R6: A rising edge with `cfg_shift_en` at 1 clears the output flip-flop, so a registered-mode cell outputs 0 in the cycle after any shift.
- R7: A rising edge with `rst_n` at 0 clears every configuration bit and the output flip-flop. After reset `cell_out` and `cfg_dout` are 0 for any `lut_in`.
- R8: Loaded with the three-input NAND of `lut_in[2:0]` in direct mode, the cell computes that NAND. Loaded with `lut_in[2]` xor `lut_in[1]` in registered mode, it acts as a next-state bit holding that xor from the previous cycle.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User and configuration clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift_en | input | 1 | Shifts the configuration chain by one place per edge |
| cfg_din | input | 1 | Serial configuration data into the chain |
| cfg_dout | output | 1 | Chain end, for feeding the next cell's `cfg_din` |
| lut_in | input | N_IN | Logic inputs; select the table entry |
| cell_out | output | 1 | Cell result, direct or registered per mode bit |

## Verification
The assertions take for granted that `cfg_shift_en` and `cfg_din` are steady around each rising edge. They also assume that the table contents only matter while shifting is off, because a registered-mode output compares against the entry selected in the previous cycle. The stimulus changes every input on the falling edge only. It drops the shift enable before it checks any logic function, and while the enable is low it drives `cfg_din` at random so that a leaking chain would show up. Two cells are chained, and the bench loads them with directed NAND and xor tables as well as with random tables and random modes.

// File: rtl/lut_cell_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the lookup-table logic cell.
// Assumes: nothing beyond IEEE 1800-2017.
package lut_cell_pkg;

    // Output selection held in the chain's mode bit.
    typedef enum logic {
        OUT_DIRECT     = 1'b0,
        OUT_REGISTERED = 1'b1
    } out_mode_e;

endpackage

// File: rtl/cfg_chain.sv
`timescale 1ns/1ps
// Module: cfg_chain
// Serial configuration store. New bits enter at index 0 and move toward
// index LEN-1 on every edge with shift_en high. The last position drives dout.
// Assumes: shift_en and din are synchronous to clk.
module cfg_chain #(
    parameter int LEN = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic           dout,
    output logic [LEN-1:0] bits
);

    logic [LEN-1:0] chain_q;

    // Shift register: clear on reset, move one place when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {chain_q[LEN-2:0], din};
        end
    end

    assign bits = chain_q;
    assign dout = chain_q[LEN-1];

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q)); // R4

    AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (chain_q[0] == $past(din))); // R2

    AST_CHAIN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (dout == $past(chain_q[LEN-2]))); // R3

endmodule

// File: rtl/lut_mux.sv
`timescale 1ns/1ps
// Module: lut_mux
// Binary multiplexer tree that picks table[sel]. The nodes are kept in a
// heap layout: the root is node 0, the children of k are 2k+1 and 2k+2, and
// the leaves are the table entries. The most significant select bit steers
// at the root.
// Assumes: table is stable while the result is used.
module lut_mux #(
    parameter int N_IN = 4
) (
    input  logic [(1<<N_IN)-1:0] table_bits,
    input  logic [N_IN-1:0]      sel,
    output logic                 y
);

    localparam int DEPTH = 1 << N_IN;
    localparam int NODES = 2 * DEPTH - 1;

    logic [NODES-1:0] node;

    genvar lvl, idx;
    generate
        // Leaves: entry j at heap index DEPTH-1+j.
        for (idx = 0; idx < DEPTH; idx++) begin : g_leaf
            assign node[DEPTH-1+idx] = table_bits[idx];
        end
        // Inner nodes: depth lvl is steered by select bit N_IN-1-lvl.
        for (lvl = 0; lvl < N_IN; lvl++) begin : g_level
            for (idx = 0; idx < (1 << lvl); idx++) begin : g_node
                localparam int K = (1 << lvl) - 1 + idx;
                assign node[K] = sel[N_IN-1-lvl] ? node[2*K+2] : node[2*K+1];
            end
        end
    endgenerate

    assign y = node[0];

endmodule

// File: rtl/out_stage.sv
`timescale 1ns/1ps
// Module: out_stage
// Optional output register. The flip-flop captures the lookup result on
// every edge and is cleared while configuration shifting is on. The mode
// bit chooses the flip-flop or the raw lookup result.
// Assumes: hold_clr is the chain shift enable.
module out_stage
    import lut_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold_clr,
    input  logic      lut_val,
    input  out_mode_e mode,
    output logic      cell_out
);

    logic ff_q;

    // State bit: cleared by reset or shifting, else captures the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr) begin
            ff_q <= 1'b0;
        end else begin
            ff_q <= lut_val;
        end
    end

    // Output selection per the configured mode.
    always_comb begin
        cell_out = (mode == OUT_REGISTERED) ? ff_q : lut_val;
    end

    AST_FF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (ff_q == 1'b0)); // R6

    AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_clr |=> (ff_q == $past(lut_val))); // R5

endmodule

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
// Module: lut_cell (top)
// Programmable logic cell: a table of 2^N_IN bits selected by lut_in, plus
// an optional output register. Chain layout: bit LEN-1 is the mode bit,
// bits DEPTH-1..0 are table entries DEPTH-1..0.
// Assumes: one clock serves both configuration and user logic.
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_shift_en,
    input  logic            cfg_din,
    output logic            cfg_dout,
    input  logic [N_IN-1:0] lut_in,
    output logic            cell_out
);

    localparam int DEPTH = 1 << N_IN;
    localparam int LEN   = DEPTH + 1;

    logic [LEN-1:0] cfg_bits;
    logic           lut_val;
    out_mode_e      mode;

    cfg_chain #(.LEN(LEN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .din      (cfg_din),
        .dout     (cfg_dout),
        .bits     (cfg_bits)
    );

    lut_mux #(.N_IN(N_IN)) u_mux (
        .table_bits (cfg_bits[DEPTH-1:0]),
        .sel        (lut_in),
        .y          (lut_val)
    );

    assign mode = out_mode_e'(cfg_bits[LEN-1]);

    out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (cfg_shift_en),
        .lut_val  (lut_val),
        .mode     (mode),
        .cell_out (cell_out)
    );

    AST_DOUT_IS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dout == 1'b0) |-> (mode == OUT_DIRECT)); // R3

endmodule

// File: tb/test_lut_cell.sv
`timescale 1ns/1ps
// Bench: two chained cells, directed NAND/xor loads plus random tables.
module test_lut_cell;

    localparam int N_IN  = 4;
    localparam int DEPTH = 1 << N_IN;
    localparam int LEN   = DEPTH + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            shift_en = 1'b0;
    logic            din = 1'b0;
    logic [N_IN-1:0] in_a = '0;
    logic [N_IN-1:0] in_b = '0;
    logic            dout_a, dout_b, out_a, out_b;

    int n_chk = 0;
    int n_fail = 0;

    logic [DEPTH-1:0] tab_a, tab_b;
    logic             mode_a, mode_b;
    logic [N_IN-1:0]  prev_a, prev_b;

    lut_cell #(.N_IN(N_IN)) i_lut_cell (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(shift_en), .cfg_din(din),
        .cfg_dout(dout_a), .lut_in(in_a), .cell_out(out_a));

    lut_cell #(.N_IN(N_IN)) i_lut_cell_b (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(shift_en), .cfg_din(dout_a),
        .cfg_dout(dout_b), .lut_in(in_b), .cell_out(out_b));

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic [DEPTH-1:0] nand3_table();
        logic [DEPTH-1:0] t;
        for (int j = 0; j < DEPTH; j++) t[j] = ~(j[0] & j[1] & j[2]);
        return t;
    endfunction

    function automatic logic [DEPTH-1:0] xor21_table();
        logic [DEPTH-1:0] t;
        for (int j = 0; j < DEPTH; j++) t[j] = j[2] ^ j[1];
        return t;
    endfunction

    // Serial order: mode bit first, then entries DEPTH-1 down to 0 (R2).
    function automatic logic stream_bit(logic [DEPTH-1:0] t, logic m, int k);
        return (k == 0) ? m : t[DEPTH-k];
    endfunction

    task automatic shift_one(logic b);
        @(negedge clk);
        shift_en = 1'b1;
        din      = b;
    endtask

    // Far cell (b) first, then near cell (a).
    task automatic load_pair(logic [DEPTH-1:0] ta, logic ma,
                             logic [DEPTH-1:0] tb, logic mb);
        for (int k = 0; k < LEN; k++) shift_one(stream_bit(tb, mb, k));
        for (int k = 0; k < LEN; k++) shift_one(stream_bit(ta, ma, k));
        @(posedge clk);
        #1;
        if (ma) chk("R6 ff cleared while shifting (a)", out_a, 1'b0);
        if (mb) chk("R6 ff cleared while shifting (b)", out_b, 1'b0);
        @(negedge clk);
        shift_en = 1'b0;
        din      = 1'($urandom);
        tab_a = ta; mode_a = ma; tab_b = tb; mode_b = mb;
        in_a = N_IN'($urandom);
        in_b = N_IN'($urandom);
        prev_a = in_a;
        prev_b = in_b;
        #1;
        chk("R2 mode bit at chain end (a)", dout_a, ma);
        chk("R3 chained mode bit at far end (b)", dout_b, mb);
    endtask

    // One user cycle: check registered results, then new inputs and direct results.
    task automatic run_cycles(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (mode_a) chk("R5/R4 registered output (a)", out_a, tab_a[prev_a]);
            if (mode_b) chk("R5/R8 registered output (b)", out_b, tab_b[prev_b]);
            din  = 1'($urandom);
            in_a = N_IN'($urandom);
            in_b = N_IN'($urandom);
            prev_a = in_a;
            prev_b = in_b;
            #1;
            if (!mode_a) chk("R1/R4 direct output (a)", out_a, tab_a[in_a]);
            if (!mode_b) chk("R1/R4 direct output (b)", out_b, tab_b[in_b]);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset out (a)", out_a, 1'b0);
        chk("R7 reset dout (a)", dout_a, 1'b0);
        chk("R7 reset dout (b)", dout_b, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: NAND direct in a, xor next-state bit registered in b.
        load_pair(nand3_table(), 1'b0, xor21_table(), 1'b1);
        for (int j = 0; j < DEPTH; j++) begin
            @(negedge clk);
            chk("R8 xor next-state (b)", out_b, prev_b[2] ^ prev_b[1]);
            in_a = N_IN'(j);
            in_b = N_IN'(j);
            prev_b = in_b;
            #1;
            chk("R8 nand3 direct (a)", out_a, ~(in_a[0] & in_a[1] & in_a[2]));
        end
        run_cycles(40);

        // Random tables and modes.
        for (int r = 0; r < 12; r++) begin
            load_pair(DEPTH'($urandom), 1'($urandom), DEPTH'($urandom), 1'($urandom));
            run_cycles(30);
        end

        // Mid-run reset clears configuration.
        load_pair('1, 1'b1, '1, 1'b0);
        run_cycles(4);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R7 mid reset out (a)", out_a, 1'b0);
        chk("R7 mid reset out (b)", out_b, 1'b0);
        chk("R7 mid reset dout (b)", dout_b, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tab_a = '0; tab_b = '0; mode_a = 1'b0; mode_b = 1'b0;
        run_cycles(8);

        summary();
        $finish;
    end

endmodule